// File: doc/BRIEF.md
# Bit-Addressable Boolean Manipulation Unit

This unit runs single-bit operations against a nibble-wide data store with 4096 locations and 12-bit addresses. It is meant for the datapath of a small controller core. Each cycle it takes an opcode, an addressing mode, address fields, a two-bit index that picks one bit of the nibble, and its own carry flag. It then does a read-modify-write on the chosen nibble in that one cycle. Its results are a new carry value and a skip request for the instruction sequencer.

Addresses come from one of two sources. In bank-relative form, a bank register is placed in front of an 8-bit offset, and the bank only counts while bank enable is high. In window form, a 4-bit index and a region selector reach the 16-entry port area at FF0H–FFFH or the 16-entry interrupt area at FB0H–FBFH, and bank selection plays no part. A third, narrow mode uses bank-relative addressing but accepts only set, clear and test.

The carry-only opcodes use none of the address fields.

Top module: `bitop_unit`

## Requirements
- R1: After reset the carry output is 0 and every bit of the store reads as 0.
- R2: With mode 2'b00 (bank-relative) the effective address is {bank, ofs} when bank_en is 1, and {4'h0, ofs} when bank_en is 0.
- R3: With mode 2'b01 (window) the effective address is {8'hFF, ofs[3:0]} when win_sel is 1 and {8'hFB, ofs[3:0]} when win_sel is 0. The values of bank, bank_en and ofs[7:4] have no effect.
- R4: Opcode 4'h1 sets and opcode 4'h2 clears the selected bit (bit_sel, 0 to 3) at the next clock edge. The other three bits of the nibble are left unchanged.
- R5: Opcode 4'h3 raises skip in the same cycle exactly when the selected bit is 1, and it changes neither the store nor the carry.
- R6: Opcodes 4'h4, 4'h5 and 4'h6 load carry, at the next edge, with carry AND bit, carry OR bit and carry XOR bit respectively, and they leave the store unchanged and skip low.
- R7: Opcode 4'h7 raises skip in the same cycle when the selected bit is 1 and clears that bit at the next edge. When the bit is 0 it raises no skip and the bit stays 0.
- R8: Opcodes 4'h8 and 4'h9 set and clear the carry at the next edge. Opcode 4'hA raises skip in the same cycle exactly when carry is 1.
- R9: In mode 2'b10 or 2'b11 (narrow, bank-relative addressing) opcodes 4'h4 to 4'h7 do nothing: no skip, carry unchanged, store unchanged. Opcodes 4'h1, 4'h2, 4'h3 and 4'h8 to 4'hA behave as in the other modes.
- R10: Carry holds its value under every opcode other than 4'h4, 4'h5, 4'h6, 4'h8 and 4'h9. Skip is 0 for every opcode other than 4'h3, 4'h7 and 4'hA, including 4'h0 and the unused codes 4'hB to 4'hF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| mode | input | 2 | Addressing mode: 00 bank-relative, 01 window, 1x narrow |
| win_sel | input | 1 | Window region: 1 port area, 0 interrupt area |
| ofs | input | 8 | Offset within bank, or window index in bits 3:0 |
| bank | input | 4 | Bank register value |
| bank_en | input | 1 | Bank enable |
| bit_sel | input | 2 | Bit position within the nibble |
| carry | output | 1 | Carry flag register |
| skip | output | 1 | Skip request, valid in the cycle of the operation |

## Verification
The skip request is combinational from the inputs and the current store, so it is due in the same cycle as the operation. The bench drives inputs just after a falling edge and samples skip a quarter period later, before the next rising edge. Changes to the carry and to the store show up one edge later. The carry is therefore compared one time unit after that rising edge. Store contents are compared through later test opcodes, and each comparison is made against a bench model that was updated at the same edge.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int BANK_W_DEF = 4;
    localparam int OFS_W_DEF  = 8;
    localparam int WIN_W_DEF  = 4;
    localparam int DATA_W_DEF = 4;

    typedef enum logic [3:0] {
        OP_NOP  = 4'h0,
        OP_SETM = 4'h1,
        OP_CLRM = 4'h2,
        OP_TSTM = 4'h3,
        OP_ANDC = 4'h4,
        OP_ORC  = 4'h5,
        OP_XORC = 4'h6,
        OP_TCLR = 4'h7,
        OP_SETC = 4'h8,
        OP_CLRC = 4'h9,
        OP_TSTC = 4'hA
    } bop_e;

    typedef enum logic [1:0] {SK_NONE, SK_BIT, SK_CY} skip_src_e;
    typedef enum logic [1:0] {BF_KEEP, BF_SET, BF_CLR} bit_fn_e;
    typedef enum logic [2:0] {CF_KEEP, CF_AND, CF_OR, CF_XOR, CF_SET, CF_CLR} cy_fn_e;

    typedef struct packed {
        logic      mem_we;
        logic      cy_we;
        skip_src_e skip_src;
        bit_fn_e   bit_fn;
        cy_fn_e    cy_fn;
    } bop_ctrl_t;

    localparam bop_ctrl_t CTRL_IDLE = '{mem_we: 1'b0, cy_we: 1'b0,
        skip_src: SK_NONE, bit_fn: BF_KEEP, cy_fn: CF_KEEP};

    function automatic logic is_narrow(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic needs_full_mode(input bop_e o);
        return (o == OP_ANDC) || (o == OP_ORC) || (o == OP_XORC) || (o == OP_TCLR);
    endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [3:0] op,
    input  logic [1:0] mode,
    output bop_ctrl_t  ctrl
);
    bop_e opc;
    assign opc = bop_e'(op);

    always_comb begin
        ctrl = CTRL_IDLE;
        if (!(is_narrow(mode) && needs_full_mode(opc))) begin
            unique case (opc)
                OP_SETM: begin ctrl.mem_we = 1'b1; ctrl.bit_fn = BF_SET; end
                OP_CLRM: begin ctrl.mem_we = 1'b1; ctrl.bit_fn = BF_CLR; end
                OP_TSTM: ctrl.skip_src = SK_BIT;
                OP_ANDC: begin ctrl.cy_we = 1'b1; ctrl.cy_fn = CF_AND; end
                OP_ORC:  begin ctrl.cy_we = 1'b1; ctrl.cy_fn = CF_OR;  end
                OP_XORC: begin ctrl.cy_we = 1'b1; ctrl.cy_fn = CF_XOR; end
                OP_TCLR: begin
                    ctrl.mem_we   = 1'b1;
                    ctrl.bit_fn   = BF_CLR;
                    ctrl.skip_src = SK_BIT;
                end
                OP_SETC: begin ctrl.cy_we = 1'b1; ctrl.cy_fn = CF_SET; end
                OP_CLRC: begin ctrl.cy_we = 1'b1; ctrl.cy_fn = CF_CLR; end
                OP_TSTC: ctrl.skip_src = SK_CY;
                default: ctrl = CTRL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bitop_addr_gen.sv
module bitop_addr_gen #(
    parameter int BANK_W = 4,
    parameter int OFS_W  = 8,
    parameter int WIN_W  = 4,
    localparam int ADDR_W = BANK_W + OFS_W,
    localparam int HI_W   = ADDR_W - WIN_W,
    parameter logic [HI_W-1:0] IO_HI  = '1,
    parameter logic [HI_W-1:0] IRQ_HI = {{(HI_W-3){1'b1}}, 3'b011}
) (
    input  logic [1:0]        mode,
    input  logic              win_sel,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [BANK_W-1:0] bank,
    input  logic              bank_en,
    output logic [ADDR_W-1:0] eff_addr
);
    logic [BANK_W-1:0] bank_eff;
    logic [HI_W-1:0]   win_hi;

    assign bank_eff = bank_en ? bank : '0;
    assign win_hi   = win_sel ? IO_HI : IRQ_HI;

    always_comb begin
        if (mode == 2'b01) eff_addr = {win_hi, ofs[WIN_W-1:0]};
        else               eff_addr = {bank_eff, ofs};
    end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
(
    input  bop_ctrl_t ctrl,
    input  logic      bit_in,
    input  logic      cy_in,
    output logic      bit_out,
    output logic      cy_out,
    output logic      skip
);
    always_comb begin
        unique case (ctrl.bit_fn)
            BF_SET:  bit_out = 1'b1;
            BF_CLR:  bit_out = 1'b0;
            default: bit_out = bit_in;
        endcase
        unique case (ctrl.cy_fn)
            CF_AND:  cy_out = cy_in & bit_in;
            CF_OR:   cy_out = cy_in | bit_in;
            CF_XOR:  cy_out = cy_in ^ bit_in;
            CF_SET:  cy_out = 1'b1;
            CF_CLR:  cy_out = 1'b0;
            default: cy_out = cy_in;
        endcase
        unique case (ctrl.skip_src)
            SK_BIT:  skip = bit_in;
            SK_CY:   skip = cy_in;
            default: skip = 1'b0;
        endcase
    end
endmodule

// File: rtl/bitop_mem.sv
module bitop_mem #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 4,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              we,
    input  logic              bit_val,
    output logic              bit_rd
);
    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] nib_rd;

    assign nib_rd = store[addr];
    assign bit_rd = nib_rd[bit_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (we) begin
            store[addr][bit_idx] <= bit_val;
        end
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int BANK_W = BANK_W_DEF,
    parameter int OFS_W  = OFS_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    localparam int ADDR_W = BANK_W + OFS_W,
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op,
    input  logic [1:0]        mode,
    input  logic              win_sel,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [BANK_W-1:0] bank,
    input  logic              bank_en,
    input  logic [IDX_W-1:0]  bit_sel,
    output logic              carry,
    output logic              skip
);
    bop_ctrl_t         ctrl;
    logic [ADDR_W-1:0] eff_addr;
    logic              bit_rd, bit_wr, cy_next;

    bitop_decode u_dec (.op(op), .mode(mode), .ctrl(ctrl));

    bitop_addr_gen #(.BANK_W(BANK_W), .OFS_W(OFS_W), .WIN_W(WIN_W_DEF)) u_agen (
        .mode(mode), .win_sel(win_sel), .ofs(ofs), .bank(bank),
        .bank_en(bank_en), .eff_addr(eff_addr)
    );

    bitop_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst(rst), .addr(eff_addr), .bit_idx(bit_sel),
        .we(ctrl.mem_we), .bit_val(bit_wr), .bit_rd(bit_rd)
    );

    bitop_alu u_alu (
        .ctrl(ctrl), .bit_in(bit_rd), .cy_in(carry),
        .bit_out(bit_wr), .cy_out(cy_next), .skip(skip)
    );

    always_ff @(posedge clk) begin
        if (rst)             carry <= 1'b0;
        else if (ctrl.cy_we) carry <= cy_next;
    end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] op,
    input logic [1:0] mode,
    input logic       carry,
    input logic       skip
);
    logic full_mode;
    assign full_mode = !mode[1];

    // R10: carry only moves under carry-writing opcodes
    a_r10_carry_hold: assert property (@(posedge clk) disable iff (rst)
        !(op inside {4'h4, 4'h5, 4'h6, 4'h8, 4'h9}) |=> $stable(carry));

    // R10: skip only from test opcodes
    a_r10_skip_src: assert property (@(posedge clk) disable iff (rst)
        skip |-> (op inside {4'h3, 4'h7, 4'hA}));

    // R8: set and clear carry
    a_r8_set_cy: assert property (@(posedge clk) disable iff (rst)
        (op == 4'h8) |=> carry);
    a_r8_clr_cy: assert property (@(posedge clk) disable iff (rst)
        (op == 4'h9) |=> !carry);
    a_r8_test_cy: assert property (@(posedge clk) disable iff (rst)
        (op == 4'hA) |-> (skip == carry));

    // R6: AND can never raise carry, OR can never drop it
    a_r6_and_no_rise: assert property (@(posedge clk) disable iff (rst)
        (op == 4'h4) |=> !$rose(carry));
    a_r6_or_no_fall: assert property (@(posedge clk) disable iff (rst)
        (op == 4'h5) |=> !$fell(carry));

    // R9: narrow mode blocks boolean and test-and-clear
    a_r9_narrow_no_skip: assert property (@(posedge clk) disable iff (rst)
        (!full_mode && op == 4'h7) |-> !skip);
    a_r9_narrow_cy_hold: assert property (@(posedge clk) disable iff (rst)
        (!full_mode && op inside {4'h4, 4'h5, 4'h6}) |=> $stable(carry));
endmodule

bind bitop_unit bitop_unit_chk u_chk (
    .clk(clk), .rst(rst), .op(op), .mode(mode), .carry(carry), .skip(skip)
);

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op = 4'h0;
    logic [1:0] mode = 2'b00;
    logic       win_sel = 1'b0;
    logic [7:0] ofs = 8'h00;
    logic [3:0] bank = 4'h0;
    logic       bank_en = 1'b0;
    logic [1:0] bit_sel = 2'b00;
    logic       carry, skip;

    int n_vec = 0;
    int n_bad = 0;
    logic [3:0] model [4096];
    logic       m_cy;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_unit u_dut (
        .clk(clk), .rst(rst), .op(op), .mode(mode), .win_sel(win_sel),
        .ofs(ofs), .bank(bank), .bank_en(bank_en), .bit_sel(bit_sel),
        .carry(carry), .skip(skip)
    );

    function automatic logic [11:0] eff(input logic [1:0] md, input logic ws,
                                        input logic [7:0] of, input logic [3:0] bk,
                                        input logic be);
        if (md == 2'b01) return {(ws ? 8'hFF : 8'hFB), of[3:0]};
        return {(be ? bk : 4'h0), of};
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (op %h mode %b)", req, act, exp, op, mode);
        end
    endtask

    task automatic step(input logic [3:0] o, input logic [1:0] md, input logic ws,
                        input logic [7:0] of, input logic [3:0] bk, input logic be,
                        input logic [1:0] bs);
        logic [11:0] a;
        logic        b, exp_skip, nb, ncy, narrow;
        @(negedge clk);
        op = o; mode = md; win_sel = ws; ofs = of; bank = bk; bank_en = be; bit_sel = bs;
        a = eff(md, ws, of, bk, be);
        b = model[a][bs];
        narrow = md[1];
        exp_skip = 1'b0; nb = b; ncy = m_cy;
        case (o)
            4'h1: nb = 1'b1;
            4'h2: nb = 1'b0;
            4'h3: exp_skip = b;
            4'h4: if (!narrow) ncy = m_cy & b;
            4'h5: if (!narrow) ncy = m_cy | b;
            4'h6: if (!narrow) ncy = m_cy ^ b;
            4'h7: if (!narrow) begin exp_skip = b; nb = 1'b0; end
            4'h8: ncy = 1'b1;
            4'h9: ncy = 1'b0;
            4'hA: exp_skip = m_cy;
            default: ;
        endcase
        #(CLK_PERIOD/4);
        if (o == 4'h3) chk("R5 test bit / R2 R3 R4 address and store", skip, exp_skip);
        else if (o == 4'h7) chk(narrow ? "R9 narrow test-clear" : "R7 test-clear skip", skip, exp_skip);
        else if (o == 4'hA) chk("R8 test carry", skip, exp_skip);
        else chk("R10 skip low", skip, exp_skip);
        @(posedge clk);
        model[a][bs] = nb;
        m_cy = ncy;
        #1;
        if (o inside {4'h4, 4'h5, 4'h6}) chk(narrow ? "R9 narrow boolean" : "R6 boolean carry", carry, m_cy);
        else if (o inside {4'h8, 4'h9}) chk("R8 set/clear carry", carry, m_cy);
        else chk("R10 carry hold", carry, m_cy);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4096; i++) model[i] = 4'h0;
        m_cy = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset carry", carry, 1'b0);
        // R1: store reads zero after reset
        step(4'h3, 2'b00, 0, 8'h00, 4'h0, 0, 2'd0);
        step(4'h3, 2'b01, 1, 8'h0F, 4'h0, 0, 2'd3);
        step(4'h3, 2'b00, 0, 8'hBE, 4'h9, 1, 2'd2);
        // R2: bank enable gates the bank field
        step(4'h1, 2'b00, 0, 8'h25, 4'h3, 1, 2'd1);
        step(4'h3, 2'b00, 0, 8'h25, 4'h3, 0, 2'd1);
        step(4'h3, 2'b00, 0, 8'h25, 4'h3, 1, 2'd1);
        // R3: windows independent of bank, alias through bank-relative
        step(4'h1, 2'b01, 1, 8'hA5, 4'h7, 1, 2'd2);
        step(4'h3, 2'b00, 0, 8'hF5, 4'hF, 1, 2'd2);
        step(4'h1, 2'b01, 0, 8'h3A, 4'h0, 0, 2'd0);
        step(4'h3, 2'b00, 0, 8'hBA, 4'hF, 1, 2'd0);
        step(4'h3, 2'b01, 0, 8'hCA, 4'h2, 1, 2'd0);
        // R4: only the selected bit moves
        step(4'h3, 2'b00, 0, 8'h25, 4'h3, 1, 2'd0);
        step(4'h2, 2'b00, 0, 8'h25, 4'h3, 1, 2'd1);
        step(4'h3, 2'b00, 0, 8'h25, 4'h3, 1, 2'd1);
        // R7: test-and-clear on set and clear bits
        step(4'h7, 2'b01, 1, 8'h05, 4'h0, 0, 2'd2);
        step(4'h7, 2'b01, 1, 8'h05, 4'h0, 0, 2'd2);
        // R9: narrow mode ignores test-clear and booleans
        step(4'h1, 2'b10, 0, 8'h11, 4'h1, 1, 2'd3);
        step(4'h7, 2'b10, 0, 8'h11, 4'h1, 1, 2'd3);
        step(4'h3, 2'b10, 0, 8'h11, 4'h1, 1, 2'd3);
        step(4'h5, 2'b11, 0, 8'h11, 4'h1, 1, 2'd3);
        // R6 / R8: carry ops
        step(4'h8, 2'b00, 0, 8'h00, 4'h0, 0, 2'd0);
        step(4'hA, 2'b00, 0, 8'h00, 4'h0, 0, 2'd0);
        step(4'h4, 2'b00, 0, 8'h00, 4'h0, 0, 2'd0);
        step(4'h5, 2'b00, 0, 8'h11, 4'h1, 1, 2'd3);
        step(4'h6, 2'b00, 0, 8'h11, 4'h1, 1, 2'd3);
        step(4'h9, 2'b10, 0, 8'h00, 4'h0, 0, 2'd0);
        // R10: unused codes
        step(4'hF, 2'b00, 0, 8'h11, 4'h1, 1, 2'd3);
        step(4'hB, 2'b01, 1, 8'h00, 4'h0, 0, 2'd0);
        // Constrained random on a small address pool
        for (int k = 0; k < 4000; k++) begin
            logic [3:0] ro;
            logic [7:0] ro_ofs;
            ro = 4'($urandom_range(0, 15));
            ro_ofs = {4'($urandom_range(0, 1) ? 4'hF : 4'h2), 4'($urandom_range(0, 3))};
            step(ro, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), ro_ofs,
                 4'($urandom_range(0, 1) ? 4'hF : 4'h3), 1'($urandom_range(0, 1)),
                 2'($urandom_range(0, 3)));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule